// File: doc/BRIEF.md
# Spectral Subtraction Noise-Floor Unit

This block sits in the frequency-domain path of a speech enhancer, between the magnitude output of a polar converter and the stage that puts magnitude and phase back together. It receives one magnitude word per frequency bin, a full frame of bins at a time, with a flag on the first bin of every frame. After a restart, the first eight frames are treated as noise only. Each bin's magnitude is summed across those frames, and the mean of the sums becomes a per-bin noise estimate.

Every later frame is enhanced one bin at a time. The noise estimate is subtracted from the bin's magnitude. The result is compared with a noise floor, which is a run-time factor times the same estimate. The larger of the two leaves the block. Nothing is emitted for the training frames. The delay from input to output is fixed, so a phase stream running beside this block can be delayed by the same number of cycles.

Top module: `spec_floor_sub`

## Requirements
- R1: After reset or a restart, the first 8 frames (a frame begins at a beat with `sof_i` high) produce no output; `enh_vld_o` stays low for all of their beats.
- R2: The noise estimate of a bin is the sum of its 8 training magnitudes shifted right by 3 bits, so any remainder is dropped (sum 807 gives 100).
- R3: The difference Z is the bin magnitude minus the noise estimate, computed signed, so a negative Z always yields the floor.
- R4: The floor F is (estimate × beta) >> 8, where `beta_i` is unsigned Q0.8 (0x80 = 0.5) and is sampled with each beat. The product is truncated to 16 bits.
- R5: The output is Z when Z is strictly greater than F. Otherwise it is F, and an equal Z also gives F.
- R6: Each enhanced beat appears on `enh_o` with `enh_vld_o` high exactly 3 cycles after it was presented. `enh_sof_o` is high only with the bin that carried `sof_i`.
- R7: A `restart_i` pulse clears the frame count. The next 8 frames retrain the estimate, and the magnitudes seen before the pulse have no effect on later outputs.
- R8: After synchronous reset, `enh_vld_o`, `enh_sof_o` and `enh_o` are all 0.
- R9: Cycles with `mag_vld_i` low are ignored. Beats that arrive after a restart but before the first `sof_i` are also ignored.
- R10: Eight full-scale magnitudes (65535) accumulate without overflow, giving an estimate of 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | One-cycle pulse that re-enters training |
| mag_vld_i | input | 1 | Input beat valid |
| sof_i | input | 1 | Beat is bin 0 of a new frame |
| mag_i | input | 16 | Unsigned bin magnitude |
| beta_i | input | 8 | Floor factor, unsigned Q0.8 |
| enh_vld_o | output | 1 | Enhanced beat valid |
| enh_sof_o | output | 1 | Enhanced beat is bin 0 |
| enh_o | output | 16 | Enhanced magnitude |

## Verification
The assertions rely on well-formed frames. Each frame opens with `sof_i` on its first beat and carries exactly the configured number of bins. `restart_i` is never raised together with a valid beat, and the first frame after a restart is complete. The bench builds every frame from complete runs of bins, with `sof_i` only on bin 0. It places idle cycles only between beats, never in place of one, and it drives restart pulses only while the input is idle. Under those conditions the checker's own frame counter, which it takes from the ports, can predict which beats must come out and when.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // Datapath widths and training length
    localparam int MAG_W        = 16;
    localparam int BETA_W       = 8;
    localparam int TRAIN_LOG2   = 3;
    localparam int TRAIN_FRAMES = 1 << TRAIN_LOG2;
    localparam int SUM_W        = MAG_W + TRAIN_LOG2;
    localparam int CNT_W        = $clog2(TRAIN_FRAMES + 2);
    localparam int LATENCY      = 3;

    // Nominal floor factor of one half in Q0.8
    localparam logic [BETA_W-1:0] DEF_BETA = BETA_W'(1 << (BETA_W - 1));

    // Role of a beat in the stream
    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,   // not a beat, or outside any frame
        BK_FIRST = 2'd1,   // first training frame: overwrite sum
        BK_ACC   = 2'd2,   // later training frame: accumulate
        BK_ENH   = 2'd3    // estimate ready: enhance
    } beat_kind_e;

    typedef struct packed {
        logic              sof;
        beat_kind_e        kind;
        logic [MAG_W-1:0]  mag;
        logic [BETA_W-1:0] beta;
    } beat_t;

    // Mean over the training frames by shift
    function automatic logic [MAG_W-1:0] noise_of(input logic [SUM_W-1:0] s);
        return MAG_W'(s >> TRAIN_LOG2);
    endfunction

    // Signed difference of magnitude and estimate
    function automatic logic signed [MAG_W:0] diff_of(input logic [MAG_W-1:0] y,
                                                      input logic [MAG_W-1:0] d);
        return $signed({1'b0, y}) - $signed({1'b0, d});
    endfunction

    // Scaled noise floor, truncated to magnitude width
    function automatic logic [MAG_W-1:0] floor_of(input logic [MAG_W-1:0] d,
                                                  input logic [BETA_W-1:0] b);
        logic [MAG_W+BETA_W-1:0] p;
        p = {{BETA_W{1'b0}}, d} * {{MAG_W{1'b0}}, b};
        return MAG_W'(p >> BETA_W);
    endfunction

    // Keep the difference only when it clears the floor
    function automatic logic [MAG_W-1:0] pick_of(input logic signed [MAG_W:0] z,
                                                 input logic [MAG_W-1:0] f);
        if (z > $signed({1'b0, f}))
            return MAG_W'(z);
        else
            return f;
    endfunction

endpackage

// File: rtl/sfs_frame_track.sv
module sfs_frame_track
    import sfs_pkg::*;
#(
    parameter int BINS = 512,
    localparam int IDX_W = $clog2(BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              mag_vld_i,
    input  logic              sof_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [BETA_W-1:0] beta_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output beat_t             s1_o,
    output logic [IDX_W-1:0]  s1_idx_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TRAIN_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] frm_cnt;   // frames opened since restart, saturating
    logic [IDX_W-1:0] bin_q;     // index of the last accepted beat
    logic [CNT_W-1:0] cnt_eff;
    logic [IDX_W-1:0] idx_c;
    logic             live;
    beat_kind_e       kind_c;

    always_comb begin
        live = mag_vld_i && !restart_i;
        if (sof_i)
            cnt_eff = (frm_cnt == CNT_SAT) ? CNT_SAT : frm_cnt + 1'b1;
        else
            cnt_eff = frm_cnt;
        idx_c = sof_i ? '0 : bin_q + 1'b1;
        if (!live || cnt_eff == '0)
            kind_c = BK_IDLE;
        else if (cnt_eff == CNT_ONE)
            kind_c = BK_FIRST;
        else if (cnt_eff == CNT_SAT)
            kind_c = BK_ENH;
        else
            kind_c = BK_ACC;
        rd_idx_o = idx_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_cnt  <= '0;
            bin_q    <= '0;
            s1_o     <= '0;
            s1_idx_o <= '0;
        end else begin
            if (restart_i) begin
                frm_cnt <= '0;
            end else if (live) begin
                frm_cnt <= cnt_eff;
                bin_q   <= idx_c;
            end
            s1_o.sof  <= sof_i;
            s1_o.kind <= kind_c;
            s1_o.mag  <= mag_i;
            s1_o.beta <= beta_i;
            s1_idx_o  <= idx_c;
        end
    end

endmodule

// File: rtl/sfs_noise_store.sv
module sfs_noise_store
    import sfs_pkg::*;
#(
    parameter int BINS = 512,
    localparam int IDX_W = $clog2(BINS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  beat_kind_e        kind_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    output logic [SUM_W-1:0]  sum_o
);

    logic [SUM_W-1:0] sums [BINS];
    logic [SUM_W-1:0] wr_data;
    logic             wr_en;

    always_comb begin
        wr_en = (kind_i == BK_FIRST) || (kind_i == BK_ACC);
        if (kind_i == BK_FIRST)
            wr_data = {{TRAIN_LOG2{1'b0}}, mag_i};
        else
            wr_data = sum_o + {{TRAIN_LOG2{1'b0}}, mag_i};
    end

    // Synchronous read for the incoming beat, write-back for the previous one
    always_ff @(posedge clk) begin
        sum_o <= sums[rd_idx_i];
        if (wr_en)
            sums[wr_idx_i] <= wr_data;
    end

endmodule

// File: rtl/sfs_floor_pipe.sv
module sfs_floor_pipe
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  beat_t             s1_i,
    input  logic [SUM_W-1:0]  sum_i,
    output logic              enh_vld_o,
    output logic              enh_sof_o,
    output logic [MAG_W-1:0]  enh_o
);

    logic [MAG_W-1:0]       d_c;
    logic signed [MAG_W:0]  z_c;
    logic [MAG_W-1:0]       f_c;

    logic                   s2_vld;
    logic                   s2_sof;
    logic signed [MAG_W:0]  s2_z;
    logic [MAG_W-1:0]       s2_f;

    always_comb begin
        d_c = noise_of(sum_i);
        z_c = diff_of(s1_i.mag, d_c);
        f_c = floor_of(d_c, s1_i.beta);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_sof <= 1'b0;
            s2_z   <= '0;
            s2_f   <= '0;
        end else begin
            s2_vld <= (s1_i.kind == BK_ENH);
            s2_sof <= (s1_i.kind == BK_ENH) && s1_i.sof;
            s2_z   <= z_c;
            s2_f   <= f_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enh_vld_o <= 1'b0;
            enh_sof_o <= 1'b0;
            enh_o     <= '0;
        end else begin
            enh_vld_o <= s2_vld;
            enh_sof_o <= s2_sof;
            if (s2_vld)
                enh_o <= pick_of(s2_z, s2_f);
        end
    end

endmodule

// File: rtl/spec_floor_sub.sv
module spec_floor_sub
    import sfs_pkg::*;
#(
    parameter int BINS = 512,
    localparam int IDX_W = $clog2(BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              mag_vld_i,
    input  logic              sof_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [BETA_W-1:0] beta_i,
    output logic              enh_vld_o,
    output logic              enh_sof_o,
    output logic [MAG_W-1:0]  enh_o
);

    logic [IDX_W-1:0] rd_idx;
    beat_t            s1_beat;
    logic [IDX_W-1:0] s1_idx;
    logic [SUM_W-1:0] bin_sum;

    sfs_frame_track #(.BINS(BINS)) u_track (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_i),
        .mag_vld_i (mag_vld_i),
        .sof_i     (sof_i),
        .mag_i     (mag_i),
        .beta_i    (beta_i),
        .rd_idx_o  (rd_idx),
        .s1_o      (s1_beat),
        .s1_idx_o  (s1_idx)
    );

    sfs_noise_store #(.BINS(BINS)) u_store (
        .clk      (clk),
        .rd_idx_i (rd_idx),
        .kind_i   (s1_beat.kind),
        .mag_i    (s1_beat.mag),
        .wr_idx_i (s1_idx),
        .sum_o    (bin_sum)
    );

    sfs_floor_pipe u_floor (
        .clk       (clk),
        .rst       (rst),
        .s1_i      (s1_beat),
        .sum_i     (bin_sum),
        .enh_vld_o (enh_vld_o),
        .enh_sof_o (enh_sof_o),
        .enh_o     (enh_o)
    );

endmodule

// File: rtl/sfs_chk.sv
module sfs_chk
    import sfs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              restart_i,
    input logic              mag_vld_i,
    input logic              sof_i,
    input logic [MAG_W-1:0]  s1_mag_i,
    input logic [BETA_W-1:0] s1_beta_i,
    input logic [SUM_W-1:0]  sum_i,
    input logic              enh_vld_o,
    input logic              enh_sof_o,
    input logic [MAG_W-1:0]  enh_o
);

    localparam int SAT = TRAIN_FRAMES + 1;

    int   frames;
    logic live_enh;
    logic [31:0] est32;
    logic [31:0] floor32;
    logic [31:0] ceil32;

    always_comb begin
        int nxt;
        nxt = sof_i ? ((frames == SAT) ? SAT : frames + 1) : frames;
        live_enh = mag_vld_i && !restart_i && (nxt == SAT);
        est32    = 32'(sum_i) >> TRAIN_LOG2;
        floor32  = (est32 * 32'(s1_beta_i)) >> BETA_W;
        ceil32   = (32'(s1_mag_i) > est32) ? 32'(s1_mag_i) : est32;
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i)
            frames <= 0;
        else if (mag_vld_i && sof_i && frames < SAT)
            frames <= frames + 1;
    end

    AST_QUIET_IN_TRAINING: assert property (@(posedge clk) disable iff (rst)
        enh_vld_o |-> $past(live_enh, 3));                               // R1

    AST_LIVE_BEAT_EMITS: assert property (@(posedge clk) disable iff (rst)
        $past(live_enh, 3) |-> enh_vld_o);                               // R6

    AST_SOF_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        enh_sof_o |-> enh_vld_o);                                        // R6

    AST_NOT_BELOW_FLOOR: assert property (@(posedge clk) disable iff (rst)
        enh_vld_o |-> (32'(enh_o) >= $past(floor32, 2)));                // R5

    AST_NOT_ABOVE_INPUTS: assert property (@(posedge clk) disable iff (rst)
        enh_vld_o |-> (32'(enh_o) <= $past(ceil32, 2)));                 // R3

endmodule

bind spec_floor_sub sfs_chk u_sfs_chk (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .mag_vld_i (mag_vld_i),
    .sof_i     (sof_i),
    .s1_mag_i  (s1_beat.mag),
    .s1_beta_i (s1_beat.beta),
    .sum_i     (bin_sum),
    .enh_vld_o (enh_vld_o),
    .enh_sof_o (enh_sof_o),
    .enh_o     (enh_o)
);

// File: tb/spec_floor_sub_bench.sv
module spec_floor_sub_bench;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart_i = 1'b0;
    logic        mag_vld_i = 1'b0;
    logic        sof_i = 1'b0;
    logic [15:0] mag_i = '0;
    logic [7:0]  beta_i = '0;
    logic        enh_vld_o;
    logic        enh_sof_o;
    logic [15:0] enh_o;

    spec_floor_sub #(.BINS(NB)) u_spec_floor_sub (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_i),
        .mag_vld_i (mag_vld_i),
        .sof_i     (sof_i),
        .mag_i     (mag_i),
        .beta_i    (beta_i),
        .enh_vld_o (enh_vld_o),
        .enh_sof_o (enh_sof_o),
        .enh_o     (enh_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int ncyc  = 0;
    bit done  = 0;

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected output beats, filled by the driver
    int exp_v  [64];
    int exp_s  [64];
    int exp_at [64];
    int n_exp = 0;
    int n_got = 0;

    always @(negedge clk) begin
        if (!rst && enh_vld_o) begin
            if (n_got >= n_exp) begin
                chk("R1 unexpected output beat", 1, 0);
            end else begin
                chk("R5 enhanced value", int'(enh_o), exp_v[n_got]);
                chk("R6 frame start flag", int'(enh_sof_o), exp_s[n_got]);
                chk("R6 latency cycle", ncyc, exp_at[n_got]);
            end
            n_got++;
        end
    end

    task automatic beat(input int m, input bit s, input int b, input bit want, input int ev);
        @(negedge clk);
        mag_vld_i = 1'b1;
        sof_i     = s;
        mag_i     = 16'(m);
        beta_i    = 8'(b);
        if (want) begin
            exp_v[n_exp]  = ev;
            exp_s[n_exp]  = int'(s);
            exp_at[n_exp] = ncyc + 3;
            n_exp++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mag_vld_i = 1'b0;
            sof_i     = 1'b0;
        end
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        mag_vld_i = 1'b0;
        sof_i     = 1'b0;
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
    endtask

    // Training magnitudes: means 100 (R2 truncation of 807), 1000, 0 (sum 7), 65535 (R10)
    function automatic int train_mag(input int f, input int b);
        case (b)
            0:       return (f == 7) ? 107 : 100;
            1:       return (f % 2 == 0) ? 900 : 1100;
            2:       return (f == 0) ? 7 : 0;
            default: return 65535;
        endcase
    endfunction

    // {gap after beat, beta, magnitude, expected}; bin = position mod 4, sof on bin 0
    localparam logic [40:0] TBL [16] = '{
        {1'b0, 8'h80, 16'd300,   16'd200},
        {1'b0, 8'h80, 16'd1200,  16'd500},
        {1'b0, 8'h80, 16'd7,     16'd7},
        {1'b0, 8'h80, 16'd0,     16'd32767},
        {1'b0, 8'h00, 16'd100,   16'd0},
        {1'b0, 8'h00, 16'd65535, 16'd64535},
        {1'b0, 8'h00, 16'd0,     16'd0},
        {1'b0, 8'h00, 16'd65535, 16'd0},
        {1'b0, 8'hFF, 16'd250,   16'd150},
        {1'b0, 8'hFF, 16'd1996,  16'd996},
        {1'b0, 8'hFF, 16'd65535, 16'd65535},
        {1'b0, 8'hFF, 16'd10,    16'd65279},
        {1'b1, 8'h40, 16'd50,    16'd25},
        {1'b0, 8'h40, 16'd1251,  16'd251},
        {1'b1, 8'h40, 16'd1,     16'd1},
        {1'b0, 8'h40, 16'd65535, 16'd16383}
    };

    initial begin
        // R8: reset state
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset valid", int'(enh_vld_o), 0);
        chk("R8 reset sof", int'(enh_sof_o), 0);
        chk("R8 reset data", int'(enh_o), 0);

        // R7: partial training with junk, then restart
        for (int f = 0; f < 3; f++)
            for (int b = 0; b < NB; b++)
                beat(60000, b == 0, 8'h80, 1'b0, 0);
        idle(2);
        pulse_restart();

        // R9: beats before the first sof after restart are ignored
        beat(60000, 1'b0, 8'h80, 1'b0, 0);
        beat(60000, 1'b0, 8'h80, 1'b0, 0);

        // R1/R2/R10: eight training frames, with idle gaps in one (R9)
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < NB; b++) begin
                beat(train_mag(f, b), b == 0, 8'h80, 1'b0, 0);
                if (f == 3) idle(2);
            end

        // R3/R4/R5/R6: table of enhanced beats
        for (int k = 0; k < 16; k++) begin
            beat(int'(TBL[k][31:16]), (k % NB) == 0, int'(TBL[k][39:32]), 1'b1,
                 int'(TBL[k][15:0]));
            if (TBL[k][40]) idle(1);
        end
        idle(8);
        chk("R1 output beat count after table", n_got, n_exp);

        // R7: retrain on flat noise of 200 after restart; floor 100 at beta one half
        pulse_restart();
        for (int f = 0; f < 8; f++)
            for (int b = 0; b < NB; b++)
                beat(200, b == 0, sfs_pkg::DEF_BETA, 1'b0, 0);
        beat(300,   1'b1, sfs_pkg::DEF_BETA, 1'b1, 100);    // R5 equal case
        beat(301,   1'b0, sfs_pkg::DEF_BETA, 1'b1, 101);
        beat(0,     1'b0, sfs_pkg::DEF_BETA, 1'b1, 100);    // R3 negative
        beat(65535, 1'b0, sfs_pkg::DEF_BETA, 1'b1, 65335);  // R7 old sums gone
        idle(8);
        chk("R7 output beat count after retraining", n_got, n_exp);
        chk("R6 idle output valid", int'(enh_vld_o), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            chk("watchdog expired", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule